// File: doc/BRIEF.md
# Highway and Farm Road Signal Controller

This block drives the signals at a crossing where a busy highway meets a lightly used farm road. The highway shows green by default. It gives way only when a vehicle is waiting on the farm road and the highway has held green for at least the long interval. After that the farm road gets a green phase. The phase ends when the farm road empties or when the long interval runs out. A yellow phase lasting the short interval sits between each green phase and the next.

The design has three parts. A four-phase sequencer chooses the lamp colours. A separate restartable interval timer tells the sequencer when the short and long durations have passed. A two-stage synchronizer conditions the asynchronous vehicle sensor. The sequencer holds no duration counts of its own. It pulses a restart to the timer on every phase change, so the number of phases stays fixed and the durations are set by parameters counted in clock cycles.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: While the synchronous active-low reset is applied, the highway lamp shows green and the farm lamp shows red on the next clock edge. The interval timer and the sensor synchronizer are cleared, whichever phase was active before.
- R2: In the highway-green phase the controller stays put unless the synchronized sensor reports a vehicle and the long interval has elapsed. It then moves to highway-yellow.
- R3: In highway-yellow the controller stays until the short interval has elapsed, then moves to farm-green.
- R4: In farm-green the controller moves to farm-yellow as soon as the synchronized sensor reports no vehicle or the long interval has elapsed.
- R5: In farm-yellow the controller stays until the short interval has elapsed, then returns to highway-green.
- R6: At least one of the two lamps shows red in every cycle, and the value 2'b11 never appears on either lamp output.
- R7: Lamp codes are 2'b00 red, 2'b01 yellow and 2'b10 green. The pairs (highway, farm) are: highway-green gives (10, 00), highway-yellow gives (01, 00), farm-green gives (00, 10) and farm-yellow gives (00, 01).
- R8: The timer restarts only when the phase changes. Its short flag rises SHORT_CYCLES cycles after a restart and its long flag rises LONG_CYCLES cycles after a restart, and both stay high until the next restart. As a result each yellow phase lasts exactly SHORT_CYCLES+1 cycles.
- R9: A change on the sensor input reaches the sequencer through two register stages. A vehicle that appears while the highway is green with the long interval already elapsed turns the highway lamp yellow on the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| farm_car_i | input | 1 | Vehicle sensor on the farm road, asynchronous, high when a vehicle waits |
| hwy_light_o | output | 2 | Highway lamp code (00 red, 01 yellow, 10 green) |
| farm_light_o | output | 2 | Farm road lamp code (00 red, 01 yellow, 10 green) |

## Verification
The hardest case to reach is an early exit from farm-green. The sensor must drop during a farm green phase, before the long interval runs out, and the drop has to pass through the synchronizer first. The stimulus sweeps every pair of vehicle-present and vehicle-absent run lengths from one to twelve cycles. The timer is set small (short 2, long 5), so vehicles leave at every offset inside the farm green phase, and both exits from farm-green and every boundary of both flags are exercised. A bench model, built from the requirements, predicts the lamps cycle by cycle.

// File: rtl/tl_pkg.sv
// Shared types of the crossing controller: the lamp code and the phase set.
// Assumes the lamp code is two bits wide and 2'b11 is unused.
package tl_pkg;
    typedef enum logic [1:0] {
        LAMP_RED = 2'b00,
        LAMP_YEL = 2'b01,
        LAMP_GRN = 2'b10
    } lamp_t;

    typedef enum logic [1:0] {
        PH_HWY_GO,
        PH_HWY_WARN,
        PH_FARM_GO,
        PH_FARM_WARN
    } phase_t;
endpackage

// File: rtl/tl_sync.sv
// Multi-stage synchronizer for one asynchronous level input.
// Assumes STAGES >= 2. The output lags the input by STAGES clock edges and clears on reset.
module tl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] shreg;

    // Shift the raw level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d_i};
    end

    assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/tl_interval_timer.sv
// Restartable interval timer with short and long elapsed flags.
// Assumes SHORT_CYCLES < LONG_CYCLES. The count saturates at LONG_CYCLES and clears on restart.
module tl_interval_timer #(
    parameter int SHORT_CYCLES = 2,
    parameter int LONG_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic short_o,
    output logic long_o
);
    localparam int CW = $clog2(LONG_CYCLES + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYCLES);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYCLES);

    logic [CW-1:0] count;

    // Count cycles since the last restart, holding at the long limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) count <= '0;
        else if (count < LONG_V) count <= count + 1'b1;
    end

    assign short_o = (count >= SHORT_V);
    assign long_o  = (count >= LONG_V);

    initial begin
        a_r8_param_order: assert (SHORT_CYCLES < LONG_CYCLES);
    end

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!short_o && !long_o));
    a_r8_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (long_o && !restart_i) |=> long_o);
    a_r8_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (short_o && !restart_i) |=> short_o);
endmodule

// File: rtl/tl_sequencer.sv
// Four-phase sequencer for the crossing. It chooses the lamp colours and pulses a timer
// restart on every phase change. Assumes the sensor input is already synchronized.
module tl_sequencer
    import tl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car_i,
    input  logic   short_i,
    input  logic   long_i,
    output logic   restart_o,
    output lamp_t  hwy_o,
    output lamp_t  farm_o
);
    phase_t phase, phase_nx;

    // Choose the next phase from the sensor and the timer flags.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_HWY_GO:    if (car_i && long_i)   phase_nx = PH_HWY_WARN;
            PH_HWY_WARN:  if (short_i)           phase_nx = PH_FARM_GO;
            PH_FARM_GO:   if (!car_i || long_i)  phase_nx = PH_FARM_WARN;
            PH_FARM_WARN: if (short_i)           phase_nx = PH_HWY_GO;
            default:                             phase_nx = PH_HWY_GO;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_HWY_GO;
        else        phase <= phase_nx;
    end

    assign restart_o = (phase_nx != phase);

    // Decode lamp colours from the phase.
    always_comb begin
        hwy_o  = LAMP_RED;
        farm_o = LAMP_RED;
        unique case (phase)
            PH_HWY_GO:    hwy_o  = LAMP_GRN;
            PH_HWY_WARN:  hwy_o  = LAMP_YEL;
            PH_FARM_GO:   farm_o = LAMP_GRN;
            PH_FARM_WARN: farm_o = LAMP_YEL;
            default:      hwy_o  = LAMP_RED;
        endcase
    end

    a_r2_hwy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_GO && !(car_i && long_i)) |=> phase == PH_HWY_GO);
    a_r3_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HWY_WARN && !short_i) |=> phase == PH_HWY_WARN);
    a_r4_farm_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_GO && (!car_i || long_i)) |=> phase == PH_FARM_WARN);
    a_r5_farm_warn_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FARM_WARN && short_i) |=> phase == PH_HWY_GO);
    a_r8_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> phase != $past(phase));
    a_r8_no_restart_stay: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_o |=> phase == $past(phase));
endmodule

// File: rtl/tl_crossing_ctrl.sv
// Top of the highway/farm crossing controller: sensor synchronizer, sequencer and
// interval timer. Durations are in clock cycles. Assumes SHORT_CYCLES < LONG_CYCLES.
module tl_crossing_ctrl
    import tl_pkg::*;
#(
    parameter int SHORT_CYCLES = 2,
    parameter int LONG_CYCLES  = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       farm_car_i,
    output logic [1:0] hwy_light_o,
    output logic [1:0] farm_light_o
);
    logic  car_s;
    logic  restart;
    logic  short_done;
    logic  long_done;
    lamp_t hwy_lamp;
    lamp_t farm_lamp;

    tl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (farm_car_i),
        .q_o   (car_s)
    );

    tl_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .car_i     (car_s),
        .short_i   (short_done),
        .long_i    (long_done),
        .restart_o (restart),
        .hwy_o     (hwy_lamp),
        .farm_o    (farm_lamp)
    );

    tl_interval_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .short_o   (short_done),
        .long_o    (long_done)
    );

    assign hwy_light_o  = hwy_lamp;
    assign farm_light_o = farm_lamp;

    a_r6_one_red: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light_o == 2'b00) || (farm_light_o == 2'b00));
    a_r6_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_light_o != 2'b11) && (farm_light_o != 2'b11));
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (hwy_light_o == 2'b10 && farm_light_o == 2'b00));
endmodule

// File: tb/test_tl_crossing_ctrl.sv
module test_tl_crossing_ctrl;
    localparam int SHORT = 2;
    localparam int LONG  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car = 1'b0;
    logic [1:0] hwy, farm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tl_crossing_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) i_tl_crossing_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .farm_car_i   (car),
        .hwy_light_o  (hwy),
        .farm_light_o (farm)
    );

    // Reference model built from the requirements: 0 hwy-green, 1 hwy-yellow, 2 farm-green, 3 farm-yellow.
    int m_ph = 0, m_prev = 0, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0;
    always @(posedge clk) begin
        int nx;
        bit sf, lf;
        sf = (m_cnt >= SHORT);
        lf = (m_cnt >= LONG);
        nx = m_ph;
        case (m_ph)
            0: if (m_s2 && lf) nx = 1;
            1: if (sf) nx = 2;
            2: if (!m_s2 || lf) nx = 3;
            default: if (sf) nx = 0;
        endcase
        m_prev <= m_ph;
        if (!rst_n) begin
            m_ph <= 0; m_cnt <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_s1 <= car; m_s2 <= m_s1;
            m_ph <= nx;
            if (nx != m_ph) m_cnt <= 0;
            else if (m_cnt < LONG) m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic [1:0] exp_hwy(int p);
        return (p == 0) ? 2'b10 : (p == 1) ? 2'b01 : 2'b00;
    endfunction
    function automatic logic [1:0] exp_farm(int p);
        return (p == 2) ? 2'b10 : (p == 3) ? 2'b01 : 2'b00;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model and check safety in the current (post-edge) cycle.
    int yel_run = 0;
    task automatic step_check();
        string tag;
        @(negedge clk);
        case (m_prev)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        if (!(m_prev == m_ph)) tag = {tag, "/R7"};
        check(tag, {hwy, farm}, {exp_hwy(m_ph), exp_farm(m_ph)});
        check("R6", {3'b0, (hwy == 2'b00 || farm == 2'b00) && hwy != 2'b11 && farm != 2'b11}, 4'd1);
        if (hwy == 2'b01) yel_run++;
        else begin
            if (yel_run != 0) check("R8", 4'(yel_run), 4'(SHORT + 1));
            yel_run = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {hwy, farm}, 4'b1000);
        rst_n = 1'b1;
        // R2: no vehicle, highway stays green.
        for (int i = 0; i < 12; i++) begin
            step_check();
            check("R2", {hwy, farm}, 4'b1000);
        end
        // R9: vehicle appears with long interval elapsed; yellow on third edge.
        car = 1'b1;
        step_check(); check("R9", {hwy, farm}, 4'b1000);
        step_check(); check("R9", {hwy, farm}, 4'b1000);
        step_check(); check("R9", {hwy, farm}, 4'b0100);
        // Run into farm green, then reset mid-phase (R1).
        for (int i = 0; i < 4; i++) step_check();
        check("R7", {hwy, farm}, 4'b0010);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {hwy, farm}, 4'b1000);
        yel_run = 0;
        rst_n = 1'b1;
        // Sweep all present/absent run-length pairs.
        for (int hi = 1; hi <= 12; hi++) begin
            for (int lo = 1; lo <= 12; lo++) begin
                car = 1'b1;
                for (int k = 0; k < hi; k++) step_check();
                car = 1'b0;
                for (int k = 0; k < lo; k++) step_check();
            end
        end
        // Long-lasting vehicle: farm green ends on the long interval (R4).
        car = 1'b1;
        for (int k = 0; k < 60; k++) step_check();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule